// File: doc/BRIEF.md
# SPI Register Slave with Bounded Burst Read and Access Trace

This block is an SPI slave in clock mode 3 (SCLK idles high, MOSI sampled on the rising edge, MISO driven on the falling edge). It sits in front of a register file. Every frame starts with a command byte whose last bit selects read or write, followed by a 16-bit address sent MSB first, followed by the data. The register file is outside the block. The block presents an address on `rd_addr` and takes back the data on `rd_data` and a width code on `rd_width`. Writes leave the block as a one-cycle `wr_en` pulse.

A read that starts inside the instantaneous-data window (0xE50C up to 0xE51B) becomes a burst. The slave sends one 32-bit word after another, each from the next address, until it has sent the top register of the window. A read that starts anywhere else moves exactly one register. Raising chip select ends any frame at once. A small trace records the address and the kind of the last completed access, plus the last data seen for each of the three access widths. Reads at dedicated addresses return the trace without changing it.

All SPI inputs pass through a synchronizer into the system clock domain, so SCLK must be much slower than `clk`.

Top module: `spi_burst_regs`

## Requirements
- R1: After reset, `spi_miso` and `wr_en` are 0, and all trace values (last address, last operation, and the 8-, 16- and 32-bit data) read back as 0.
- R2: In a write frame (command bit 0 = 0), the data bits are taken MSB first. Their count comes from `rd_width` for the addressed register: code 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. After the last data bit, `wr_en` pulses for exactly one cycle, with `wr_addr` set to the address and `wr_data` set to the data, zero-extended.
- R3: In a read frame (command bit 0 = 1) whose address is outside the burst window, the register's bits go out MSB first. The first bit is driven on the falling SCLK edge that follows the last address bit, and the count of bits follows the width code. After that single register, `spi_miso` stays 0 for the rest of the frame.
- R4: A read that starts at an address from 0xE50C to 0xE51B streams 32-bit words, whatever `rd_width` says. The words come from consecutive addresses, start at the start address, and need no further command.
- R5: Once the word at 0xE51B has been sent, the burst ends. Further SCLK cycles in the same frame give `spi_miso` = 0.
- R6: Raising chip select at any bit aborts the frame. A write cut short gives no `wr_en`. A partly sent word leaves the trace unchanged. The next frame decodes from its first command bit.
- R7: Each completed data word updates the last address to that word's address and the last operation to 0x01 (read) or 0x02 (write). In a burst, the last completed word is the one recorded.
- R8: Each completed word also stores its data in the trace register that matches its width (8, 16 or 32 bits). The other two data trace registers keep their values.
- R9: The trace is read at five addresses starting at 0xE7F0: offset 0 gives the last address (16 bits), 1 the last operation (8 bits), 2 the 8-bit data, 3 the 16-bit data and 4 the 32-bit data. Any access to these addresses leaves the trace unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, idles high |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| rd_addr | output | 16 | Register address being served |
| rd_data | input | 32 | Register value at `rd_addr` |
| rd_width | input | 2 | Width code of the register at `rd_addr` |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | 16 | Write address |
| wr_data | output | 32 | Write data, zero-extended |

## Verification
The assertions assume that each SCLK phase lasts well beyond the synchronizer delay plus one cycle, so that a register load finishes before the next SCLK edge arrives. They also assume that MOSI only changes together with a falling SCLK edge and that `rd_data` and `rd_width` follow `rd_addr` combinationally. The bench keeps within these limits: it holds every SCLK half period for eight system clocks, changes MOSI and chip select only on falling clock edges, and models the register file as a pure function of `rd_addr`.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
   typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA, PH_DONE} spi_phase_t;

   localparam logic [1:0] AW_8  = 2'd0;
   localparam logic [1:0] AW_16 = 2'd1;
   localparam logic [1:0] AW_32 = 2'd2;

   localparam logic [7:0] OP_NONE  = 8'h00;
   localparam logic [7:0] OP_READ  = 8'h01;
   localparam logic [7:0] OP_WRITE = 8'h02;

   function automatic int unsigned width_bits(input logic [1:0] code);
      case (code)
         AW_8:    return 8;
         AW_16:   return 16;
         default: return 32;
      endcase
   endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
   parameter int N = 3,
   parameter int STAGES = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] dout
);
   logic [N-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) st[s] <= RST_VAL;
      end else begin
         st[0] <= din;
         for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
      end
   end

   assign dout = st[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
   import spi_burst_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int CMD_W  = 8,
   parameter logic [ADDR_W-1:0] WIN_LO = 16'hE50C,
   parameter logic [ADDR_W-1:0] WIN_HI = 16'hE51B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              mosi,
   input  logic [1:0]        width_i,
   input  logic [DATA_W-1:0] word_i,
   output logic [ADDR_W-1:0] cur_addr_o,
   output logic              miso_o,
   output logic              evt_o,
   output logic              evt_read_o,
   output logic [ADDR_W-1:0] evt_addr_o,
   output logic [DATA_W-1:0] evt_data_o,
   output logic [1:0]        evt_width_o
);
   localparam int MAXN  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
   localparam int CNT_W = $clog2(MAXN + 1);

   spi_phase_t        phase;
   logic [CNT_W-1:0]  cnt;
   logic              sclk_q, is_read, in_burst, load_pend;
   logic [1:0]        width_q;
   logic [DATA_W-1:0] tx, word_q;
   logic [DATA_W-2:0] rx;
   logic              rise, fall, last_data;
   logic [DATA_W-1:0] rx_next;
   logic [ADDR_W-1:0] addr_next;

   function automatic logic [DATA_W-1:0] data_mask(input logic [1:0] code);
      int unsigned b;
      b = width_bits(code);
      if (b >= DATA_W) return '1;
      return (DATA_W'(1) << b) - DATA_W'(1);
   endfunction

   assign rise      = sclk & ~sclk_q;
   assign fall      = ~sclk & sclk_q;
   assign rx_next   = {rx, mosi};
   assign addr_next = {cur_addr_o[ADDR_W-2:0], mosi};
   assign last_data = (cnt == CNT_W'(width_bits(width_q) - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase       <= PH_CMD;
         cnt         <= '0;
         sclk_q      <= 1'b1;
         is_read     <= 1'b0;
         in_burst    <= 1'b0;
         load_pend   <= 1'b0;
         width_q     <= AW_8;
         tx          <= '0;
         word_q      <= '0;
         rx          <= '0;
         cur_addr_o  <= '0;
         miso_o      <= 1'b0;
         evt_o       <= 1'b0;
         evt_read_o  <= 1'b0;
         evt_addr_o  <= '0;
         evt_data_o  <= '0;
         evt_width_o <= AW_8;
      end else begin
         sclk_q <= sclk;
         evt_o  <= 1'b0;
         if (cs_n) begin
            phase     <= PH_CMD;
            cnt       <= '0;
            miso_o    <= 1'b0;
            in_burst  <= 1'b0;
            load_pend <= 1'b0;
         end else begin
            if (load_pend) begin
               load_pend <= 1'b0;
               width_q   <= width_i;
               word_q    <= word_i;
               tx        <= word_i << (DATA_W - width_bits(width_i));
            end
            if (fall) begin
               if (phase == PH_DATA && is_read) begin
                  miso_o <= tx[DATA_W-1];
                  tx     <= tx << 1;
               end else begin
                  miso_o <= 1'b0;
               end
            end
            if (rise) begin
               case (phase)
                  PH_CMD: begin
                     if (cnt == CNT_W'(CMD_W - 1)) begin
                        is_read <= mosi;
                        phase   <= PH_ADDR;
                        cnt     <= '0;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  PH_ADDR: begin
                     cur_addr_o <= addr_next;
                     if (cnt == CNT_W'(ADDR_W - 1)) begin
                        phase     <= PH_DATA;
                        cnt       <= '0;
                        load_pend <= 1'b1;
                        in_burst  <= is_read && (addr_next >= WIN_LO) && (addr_next <= WIN_HI);
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  PH_DATA: begin
                     rx <= rx_next[DATA_W-2:0];
                     if (last_data) begin
                        evt_o       <= 1'b1;
                        evt_read_o  <= is_read;
                        evt_addr_o  <= cur_addr_o;
                        evt_width_o <= width_q;
                        evt_data_o  <= is_read ? word_q : (rx_next & data_mask(width_q));
                        if (in_burst && cur_addr_o != WIN_HI) begin
                           cur_addr_o <= cur_addr_o + 1'b1;
                           cnt        <= '0;
                           load_pend  <= 1'b1;
                        end else begin
                           phase    <= PH_DONE;
                           in_burst <= 1'b0;
                        end
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   // R2
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |=> !evt_o);

   // R6
   abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (!miso_o && !evt_o));

   // R5
   burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_burst |-> (cur_addr_o >= WIN_LO && cur_addr_o <= WIN_HI));

   // R4
   burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_burst && $past(in_burst) && cur_addr_o != $past(cur_addr_o))
         |-> (cur_addr_o == $past(cur_addr_o) + 1'b1));
endmodule

// File: rtl/spi_access_trace.sv
module spi_access_trace
   import spi_burst_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter logic [ADDR_W-1:0] TRACE_BASE = 16'hE7F0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_i,
   input  logic              evt_read_i,
   input  logic [ADDR_W-1:0] evt_addr_i,
   input  logic [DATA_W-1:0] evt_data_i,
   input  logic [1:0]        evt_width_i,
   input  logic [ADDR_W-1:0] sel_addr_i,
   output logic              hit_o,
   output logic [DATA_W-1:0] val_o,
   output logic [1:0]        width_o
);
   localparam int NREG = 5;

   logic [ADDR_W-1:0] last_addr;
   logic [7:0]        last_op;
   logic              upd;
   logic [ADDR_W-1:0] off;

   function automatic logic in_trace(input logic [ADDR_W-1:0] a);
      return (a >= TRACE_BASE) && ((a - TRACE_BASE) < ADDR_W'(NREG));
   endfunction

   assign upd   = evt_i && !in_trace(evt_addr_i);
   assign off   = sel_addr_i - TRACE_BASE;
   assign hit_o = in_trace(sel_addr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_addr <= '0;
         last_op   <= OP_NONE;
      end else if (upd) begin
         last_addr <= evt_addr_i;
         last_op   <= evt_read_i ? OP_READ : OP_WRITE;
      end
   end

   for (genvar g = 0; g < 3; g++) begin : g_dtr
      localparam int W = 8 << g;
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               q <= '0;
         else if (upd && evt_width_i == 2'(g))     q <= evt_data_i[W-1:0];
      end
   end

   always_comb begin
      val_o   = '0;
      width_o = AW_8;
      case (off[2:0])
         3'd0: begin val_o = DATA_W'(last_addr);  width_o = AW_16; end
         3'd1: begin val_o = DATA_W'(last_op);    width_o = AW_8;  end
         3'd2: begin val_o = DATA_W'(g_dtr[0].q); width_o = AW_8;  end
         3'd3: begin val_o = DATA_W'(g_dtr[1].q); width_o = AW_16; end
         3'd4: begin val_o = DATA_W'(g_dtr[2].q); width_o = AW_32; end
         default: ;
      endcase
   end

   // R9
   trace_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> ($stable(last_addr) && $stable(last_op)));

   // R7
   trace_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_op != OP_NONE) |-> (last_op == OP_READ || last_op == OP_WRITE));

   // R8
   trace_one_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({!$stable(g_dtr[0].q), !$stable(g_dtr[1].q), !$stable(g_dtr[2].q)}) <= 1);
endmodule

// File: rtl/spi_burst_regs.sv
module spi_burst_regs
   import spi_burst_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 32,
   parameter int CMD_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] WIN_LO     = 16'hE50C,
   parameter logic [ADDR_W-1:0] WIN_HI     = 16'hE51B,
   parameter logic [ADDR_W-1:0] TRACE_BASE = 16'hE7F0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [1:0]        rd_width,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   initial begin : param_chk
      assert (DATA_W == 32);
      assert (ADDR_W >= 16);
      assert (CMD_W >= 1);
      assert (SYNC_STAGES >= 2);
      assert (WIN_LO <= WIN_HI);
      assert (TRACE_BASE > WIN_HI || TRACE_BASE + 4 < WIN_LO);
   end

   logic              cs_s, sclk_s, mosi_s;
   logic              evt, evt_read, trace_hit;
   logic [ADDR_W-1:0] evt_addr;
   logic [DATA_W-1:0] evt_data, trace_val, word_sel;
   logic [1:0]        evt_width, trace_width, width_sel;
   logic              in_win;

   spi_in_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({spi_cs_n, spi_sclk, spi_mosi}),
      .dout ({cs_s, sclk_s, mosi_s})
   );

   assign in_win    = (rd_addr >= WIN_LO) && (rd_addr <= WIN_HI);
   assign word_sel  = trace_hit ? trace_val : rd_data;
   assign width_sel = trace_hit      ? trace_width :
                      in_win         ? AW_32 :
                      (rd_width == 2'd3) ? AW_32 : rd_width;

   spi_frame_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W),
      .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_s),
      .sclk       (sclk_s),
      .mosi       (mosi_s),
      .width_i    (width_sel),
      .word_i     (word_sel),
      .cur_addr_o (rd_addr),
      .miso_o     (spi_miso),
      .evt_o      (evt),
      .evt_read_o (evt_read),
      .evt_addr_o (evt_addr),
      .evt_data_o (evt_data),
      .evt_width_o(evt_width)
   );

   spi_access_trace #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRACE_BASE(TRACE_BASE)
   ) u_trace (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt),
      .evt_read_i (evt_read),
      .evt_addr_i (evt_addr),
      .evt_data_i (evt_data),
      .evt_width_i(evt_width),
      .sel_addr_i (rd_addr),
      .hit_o      (trace_hit),
      .val_o      (trace_val),
      .width_o    (trace_width)
   );

   assign wr_en   = evt & ~evt_read;
   assign wr_addr = evt_addr;
   assign wr_data = evt_data;
endmodule

// File: tb/spi_burst_regs_tb.sv
module spi_burst_regs_tb;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
   logic        miso;
   logic [15:0] rd_addr, wr_addr;
   logic [31:0] rd_data, wr_data;
   logic [1:0]  rd_width;
   logic        wr_en;

   int n_chk = 0, n_bad = 0;
   int wr_cnt = 0;
   logic [15:0] wr_a = '0;
   logic [31:0] wr_d = '0;
   logic [1023:0] cap;

   function automatic logic [31:0] model(input logic [15:0] a);
      return {a, a ^ 16'hA5C3};
   endfunction

   assign rd_data  = model(rd_addr);
   assign rd_width = rd_addr[1:0];

   spi_burst_regs u_dut (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
      .spi_mosi(mosi), .spi_miso(miso), .rd_addr(rd_addr), .rd_data(rd_data),
      .rd_width(rd_width), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   always @(posedge clk) if (wr_en) begin
      wr_cnt <= wr_cnt + 1;
      wr_a   <= wr_addr;
      wr_d   <= wr_data;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic spi_frame(input logic rd, input logic [15:0] addr,
                            input logic [31:0] wdata, input int wbits, input int nbits);
      logic [23:0] hdr;
      hdr = {7'b1010101, rd, addr};
      @(negedge clk) cs_n = 1'b0;
      repeat (8) @(negedge clk);
      for (int i = 0; i < 24 + nbits; i++) begin
         sclk = 1'b0;
         if (i < 24) mosi = hdr[23-i];
         else if (i - 24 < wbits) mosi = wdata[wbits-1-(i-24)];
         else mosi = 1'b0;
         repeat (8) @(negedge clk);
         if (i >= 24) cap[i-24] = miso;
         sclk = 1'b1;
         repeat (8) @(negedge clk);
      end
      repeat (8) @(negedge clk);
      cs_n = 1'b1;
      repeat (16) @(negedge clk);
   endtask

   function automatic logic [31:0] capw(input int s, input int n);
      logic [31:0] v = '0;
      for (int j = 0; j < n; j++) v = (v << 1) | 32'(cap[s+j]);
      return v;
   endfunction

   task automatic read_trace(input int off, input int bits, output logic [31:0] v);
      spi_frame(1'b1, 16'hE7F0 + 16'(off), 32'h0, 0, bits);
      v = capw(0, bits);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 miso after reset", 32'(miso), 32'h0);
      check("R1 wr_en after reset", 32'(wr_en), 32'h0);
      read_trace(0, 16, v); check("R1 last addr reset", v, 32'h0);
      read_trace(1, 8, v);  check("R1 last op reset", v, 32'h0);
      read_trace(4, 32, v); check("R1 data32 reset", v, 32'h0);
   endtask

   task automatic t_writes();
      logic [31:0] v;
      int c0;
      c0 = wr_cnt;
      spi_frame(1'b0, 16'h1230, 32'h5A, 8, 8);
      check("R2 write8 count", 32'(wr_cnt - c0), 32'd1);
      check("R2 write8 addr", 32'(wr_a), 32'h1230);
      check("R2 write8 data", wr_d, 32'h5A);
      spi_frame(1'b0, 16'h1231, 32'hBEEF, 16, 16);
      check("R2 write16 data", wr_d, 32'hBEEF);
      spi_frame(1'b0, 16'h1232, 32'hDEADBEEF, 32, 32);
      check("R2 write32 data", wr_d, 32'hDEADBEEF);
      spi_frame(1'b0, 16'h1233, 32'h0BADF00D, 32, 32);
      check("R2 write code3 addr", 32'(wr_a), 32'h1233);
      check("R2 write code3 data", wr_d, 32'h0BADF00D);
      check("R2 write total count", 32'(wr_cnt - c0), 32'd4);
      read_trace(0, 16, v); check("R7 last addr after writes", v, 32'h1233);
      read_trace(1, 8, v);  check("R7 last op write", v, 32'h02);
      read_trace(2, 8, v);  check("R8 data8 after writes", v, 32'h5A);
      read_trace(3, 16, v); check("R8 data16 after writes", v, 32'hBEEF);
      read_trace(4, 32, v); check("R8 data32 after writes", v, 32'h0BADF00D);
   endtask

   task automatic t_single_reads();
      logic [31:0] v, m1, m0;
      m1 = model(16'h2001);
      m0 = model(16'h2000);
      spi_frame(1'b1, 16'h2001, 32'h0, 0, 24);
      check("R3 read16 data", capw(0, 16), {16'h0, m1[15:0]});
      check("R3 read16 tail low", capw(16, 8), 32'h0);
      spi_frame(1'b1, 16'h2000, 32'h0, 0, 16);
      check("R3 read8 data", capw(0, 8), {24'h0, m0[7:0]});
      check("R3 read8 tail low", capw(8, 8), 32'h0);
      spi_frame(1'b1, 16'h3002, 32'h0, 0, 64);
      check("R3 out-of-window read32", capw(0, 32), model(16'h3002));
      check("R3 out-of-window no increment", capw(32, 32), 32'h0);
      read_trace(0, 16, v); check("R7 last addr after read", v, 32'h3002);
      read_trace(1, 8, v);  check("R7 last op read", v, 32'h01);
      read_trace(2, 8, v);  check("R8 data8 after read", v, {24'h0, m0[7:0]});
      read_trace(3, 16, v); check("R8 data16 after read", v, {16'h0, m1[15:0]});
      read_trace(4, 32, v); check("R8 data32 after read", v, model(16'h3002));
      read_trace(0, 16, v); check("R9 trace read leaves last addr", v, 32'h3002);
      read_trace(1, 8, v);  check("R9 trace read leaves last op", v, 32'h01);
   endtask

   task automatic t_bursts();
      logic [31:0] v;
      spi_frame(1'b1, 16'hE50C, 32'h0, 0, 17 * 32);
      for (int k = 0; k < 16; k++)
         check($sformatf("R4 full burst word %0d", k), capw(32 * k, 32), model(16'hE50C + 16'(k)));
      check("R5 full burst ends at window top", capw(512, 32), 32'h0);
      read_trace(0, 16, v); check("R7 burst last addr", v, 32'hE51B);
      read_trace(4, 32, v); check("R8 burst data32", v, model(16'hE51B));
      spi_frame(1'b1, 16'hE519, 32'h0, 0, 4 * 32);
      for (int k = 0; k < 3; k++)
         check($sformatf("R4 tail burst word %0d", k), capw(32 * k, 32), model(16'hE519 + 16'(k)));
      check("R5 tail burst stops", capw(96, 32), 32'h0);
   endtask

   task automatic t_aborts();
      logic [31:0] v, m1;
      int c0;
      c0 = wr_cnt;
      spi_frame(1'b0, 16'h1232, 32'hFFFF0000, 32, 10);
      check("R6 aborted write no strobe", 32'(wr_cnt - c0), 32'd0);
      read_trace(0, 16, v); check("R6 aborted write keeps trace", v, 32'hE51B);
      spi_frame(1'b1, 16'hE510, 32'h0, 0, 40);
      check("R6 burst word before abort", capw(0, 32), model(16'hE510));
      read_trace(0, 16, v); check("R6 R7 partial word not traced", v, 32'hE510);
      read_trace(4, 32, v); check("R6 data32 after abort", v, model(16'hE510));
      m1 = model(16'h2001);
      spi_frame(1'b1, 16'h2001, 32'h0, 0, 16);
      check("R6 frame after abort decodes", capw(0, 16), {16'h0, m1[15:0]});
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_writes();
      t_single_reads();
      t_bursts();
      t_aborts();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule